// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits between five interrupt sources and a small processor core. It takes requests from two external pins, two timer overflow lines and one serial event line. It masks them with a global enable and per-source enables, then chooses one winner using a one-bit priority per source and a fixed polling order. It offers the winner to the core as a 16-bit handler address.

The core takes the offer with a one-cycle `irq_ack`. That pulse marks the winner's priority level as in service. It also clears the winner's captured edge, if the winner is an external source in edge mode. When the handler finishes, the core pulses `irq_ret`, which ends service of the most recently entered level.

Each external pin can be sampled as a level or captured on a falling edge. Timer and serial inputs are level requests, and the peripheral that raised one keeps it asserted until it is serviced.

Control is a two-state machine:

- **IDLE**: no offer is outstanding.
- **OFFER**: `irq_valid` is high, and the latched vector is shown on `irq_vector`.

It has two transitions:

- **GRANT** (IDLE to OFFER): taken when the arbiter finds an admissible winner.
- **ACCEPT** (OFFER to IDLE): taken on `irq_ack`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When the global enable (bit 5 of the enable register) is 0, no offer is made, whatever the per-source enable bits hold.
- R2: A source whose enable bit is 0 is never offered. Enable bits 0..4 belong to external 0, timer 0, external 1, timer 1 and serial, in that order. Priority register bits 0..4 use the same order, and a 1 means high level.
- R3: The vector for source index i (in the R2 order) is 0x0003 + 8*i, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R4: Among pending requests of one level, the lowest index in the R2 order wins.
- R5: When high-level and low-level requests are pending together, a high-level one wins.
- R6: While the low level is in service, no further low-level request is offered.
- R7: While only the low level is in service, a high-level request is offered.
- R8: While the high level is in service, no request of either level is offered.
- R9: `irq_ret` clears the high in-service flag if it is set, otherwise the low one. The flags appear on `in_svc_hi` and `in_svc_lo`.
- R10: An external pin in edge mode (mode bit 1) requests once per falling edge. Accepting its vector clears the captured edge, so holding the pin low produces no second offer.
- R11: A level-mode or held request that was blocked is offered after `irq_ret` if it is still asserted.
- R12: After reset, `irq_valid`, `in_svc_hi` and `in_svc_lo` are 0. Once raised, `irq_valid` and `irq_vector` hold steady until `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 2 | External request pins, active low |
| ext_edge_mode | input | 2 | 1 = falling-edge capture, 0 = level |
| tmr_ovf | input | 2 | Timer overflow requests, active high |
| ser_evt | input | 1 | Serial event request, active high |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | Enable register value; bit 5 is the global enable |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 5 | Priority register value, 1 = high |
| irq_ack | input | 1 | Core accepts the current offer |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_valid | output | 1 | An offer is outstanding |
| irq_vector | output | 16 | Handler address of the offer |
| in_svc_hi | output | 1 | High level in service |
| in_svc_lo | output | 1 | Low level in service |

## Verification
A wrong in-service flag shows directly on `in_svc_hi` or `in_svc_lo` one cycle after the `irq_ack` or `irq_ret` that should have changed it. It also shows as an offer that is missing or arrives too early within a few cycles of a pending request. A lost or stuck edge capture shows as a missing or repeated offer one to three cycles after a pin change or an `irq_ret`. An arbitration fault shows as a wrong `irq_vector` on the first cycle that `irq_valid` is high. The directed scenarios set up each of these situations explicitly and compare the ports with values worked out from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_EXT    = 2;
    localparam int NUM_SRC    = 2 * NUM_EXT + 1;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } irq_state_e;

    function automatic logic [VEC_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
        return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
    endfunction
endpackage

// File: rtl/irq_ext_input.sv
module irq_ext_input (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    logic samp_q, prev_q, flag_q;

    // Two register stages give a clean falling-edge detect.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b1;
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            samp_q <= pin_n;
            prev_q <= samp_q;
            if (prev_q && !samp_q)
                flag_q <= 1'b1;        // a new edge wins over a clear
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assign req = edge_mode ? flag_q : !samp_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     pending,
    input  logic [N-1:0]     pri,
    input  logic             busy_hi,
    input  logic             busy_lo,
    output logic             win,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_hi
);
    logic hi_ok, lo_ok;

    assign hi_ok = !busy_hi;
    assign lo_ok = !busy_hi && !busy_lo;

    always_comb begin
        win     = 1'b0;
        win_idx = '0;
        win_hi  = 1'b0;
        // Downward scans: the lowest index is written last and wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (lo_ok && pending[i] && !pri[i]) begin
                win     = 1'b1;
                win_idx = IDX_W'(i);
                win_hi  = 1'b0;
            end
        end
        // The high-level scan runs second and overrides any low choice.
        for (int i = N - 1; i >= 0; i--) begin
            if (hi_ok && pending[i] && pri[i]) begin
                win     = 1'b1;
                win_idx = IDX_W'(i);
                win_hi  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_hi,
    input  logic ret,
    output logic in_hi,
    output logic in_lo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_hi <= 1'b0;
            in_lo <= 1'b0;
        end else begin
            if (ret) begin
                if (in_hi)
                    in_hi <= 1'b0;
                else
                    in_lo <= 1'b0;
            end
            if (take) begin
                if (take_hi)
                    in_hi <= 1'b1;
                else
                    in_lo <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ext_req_n,
    input  logic [1:0]       ext_edge_mode,
    input  logic [1:0]       tmr_ovf,
    input  logic             ser_evt,
    input  logic             en_we,
    input  logic [5:0]       en_wdata,
    input  logic             pri_we,
    input  logic [4:0]       pri_wdata,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic             irq_valid,
    output logic [15:0]      irq_vector,
    output logic             in_svc_hi,
    output logic             in_svc_lo
);
    logic [NUM_SRC:0]   en_q;
    logic [NUM_SRC-1:0] pri_q;
    logic [NUM_SRC-1:0] src_req;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_EXT-1:0] ext_clr;

    irq_state_e         state_q, state_d;
    logic [IDX_W-1:0]   sel_idx_q;
    logic               sel_hi_q;
    logic               win, win_hi, accept;
    logic [IDX_W-1:0]   win_idx;

    // Enable and priority registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pri_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wdata;
            if (pri_we) pri_q <= pri_wdata;
        end
    end

    // Source slots in polling order: external k at 2k, timer k at 2k+1, serial last.
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        irq_ext_input u_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_req_n[k]),
            .edge_mode (ext_edge_mode[k]),
            .clr       (ext_clr[k]),
            .req       (ext_req[k])
        );
        assign ext_clr[k]      = accept && (sel_idx_q == IDX_W'(2 * k));
        assign src_req[2*k]    = ext_req[k];
        assign src_req[2*k+1]  = tmr_ovf[k];
    end
    assign src_req[NUM_SRC-1] = ser_evt;

    assign pending = src_req & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[NUM_SRC]}};

    irq_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .pending (pending),
        .pri     (pri_q),
        .busy_hi (in_svc_hi),
        .busy_lo (in_svc_lo),
        .win     (win),
        .win_idx (win_idx),
        .win_hi  (win_hi)
    );

    assign accept = (state_q == ST_OFFER) && irq_ack;

    irq_level_track u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (accept),
        .take_hi (sel_hi_q),
        .ret     (irq_ret),
        .in_hi   (in_svc_hi),
        .in_lo   (in_svc_lo)
    );

    // Next-state logic: GRANT from IDLE, ACCEPT from OFFER.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win)     state_d = ST_OFFER;
            ST_OFFER: if (irq_ack) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register; the winner is latched on GRANT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_idx_q <= '0;
            sel_hi_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && win) begin
                sel_idx_q <= win_idx;
                sel_hi_q  <= win_hi;
            end
        end
    end

    // Outputs.
    always_comb begin
        irq_valid  = 1'b0;
        irq_vector = '0;
        unique case (state_q)
            ST_IDLE:  irq_valid = 1'b0;
            ST_OFFER: begin
                irq_valid  = 1'b1;
                irq_vector = vector_of(sel_idx_q);
            end
            default:  irq_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_valid,
    input logic        irq_ack,
    input logic [15:0] irq_vector,
    input logic        irq_ret,
    input logic        in_svc_hi,
    input logic        in_svc_lo,
    input logic        glob_en
);
    assert_offer_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vector)));

    assert_global_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(glob_en));

    assert_hi_blocks_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> !$past(in_svc_hi));

    assert_vector_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector[2:0] == 3'd3 && irq_vector <= 16'h0023));

    assert_ret_clears_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && in_svc_hi && !irq_ack) |=> !in_svc_hi);

    assert_ret_clears_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !in_svc_hi && in_svc_lo && !irq_ack) |=> !in_svc_lo);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_valid  (irq_valid),
    .irq_ack    (irq_ack),
    .irq_vector (irq_vector),
    .irq_ret    (irq_ret),
    .in_svc_hi  (in_svc_hi),
    .in_svc_lo  (in_svc_lo),
    .glob_en    (en_q[5])
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_req_n = 2'b11;
    logic [1:0]  ext_edge_mode = 2'b00;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_evt = 1'b0;
    logic        en_we = 1'b0;
    logic [5:0]  en_wdata = '0;
    logic        pri_we = 1'b0;
    logic [4:0]  pri_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_valid;
    logic [15:0] irq_vector;
    logic        in_svc_hi, in_svc_lo;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .ext_edge_mode(ext_edge_mode),
        .tmr_ovf(tmr_ovf), .ser_evt(ser_evt), .en_we(en_we), .en_wdata(en_wdata),
        .pri_we(pri_we), .pri_wdata(pri_wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_valid(irq_valid), .irq_vector(irq_vector),
        .in_svc_hi(in_svc_hi), .in_svc_lo(in_svc_lo)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_en(input logic [5:0] v);
        en_we = 1'b1; en_wdata = v; tick(); en_we = 1'b0;
    endtask

    task automatic set_pri(input logic [4:0] v);
        pri_we = 1'b1; pri_wdata = v; tick(); pri_we = 1'b0;
    endtask

    // Waits up to n cycles for an offer; reports whether one came and its vector.
    task automatic wait_offer(input int n, output bit seen, output logic [15:0] v);
        seen = 1'b0; v = '0;
        for (int i = 0; i < n; i++) begin
            if (irq_valid) begin seen = 1'b1; v = irq_vector; break; end
            tick();
        end
    endtask

    task automatic accept();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic do_ret();
        irq_ret = 1'b1; tick(); irq_ret = 1'b0;
    endtask

    task automatic expect_vec(input logic [15:0] exp, input string req);
        bit seen; logic [15:0] v;
        wait_offer(8, seen, v);
        check(seen && v == exp, req, seen ? int'(v) : -1, int'(exp));
    endtask

    task automatic expect_none(input string req);
        bit seen; logic [15:0] v;
        wait_offer(8, seen, v);
        check(!seen, req, int'(v), 0);
    endtask

    task automatic quiesce();
        ext_req_n = 2'b11; tmr_ovf = 2'b00; ser_evt = 1'b0; ext_edge_mode = 2'b00;
        set_en(6'h00); set_pri(5'h00);
        repeat (3) tick();
    endtask

    task automatic t_reset();
        check(irq_valid == 1'b0, "R12 reset valid", int'(irq_valid), 0);
        check(in_svc_hi == 1'b0 && in_svc_lo == 1'b0, "R12 reset in-service",
              int'({in_svc_hi, in_svc_lo}), 0);
    endtask

    task automatic t_global_mask();
        set_en(6'b011111);
        tmr_ovf[0] = 1'b1;
        expect_none("R1 global off masks all");
        tmr_ovf[0] = 1'b0;
        quiesce();
    endtask

    task automatic t_src_enable();
        set_en(6'b111101);
        tmr_ovf[0] = 1'b1;
        expect_none("R2 disabled source ignored");
        tmr_ovf[0] = 1'b0;
        quiesce();
    endtask

    task automatic drive_src(input int i, input logic v);
        case (i)
            0: ext_req_n[0] = !v;
            1: tmr_ovf[0]   = v;
            2: ext_req_n[1] = !v;
            3: tmr_ovf[1]   = v;
            default: ser_evt = v;
        endcase
    endtask

    task automatic t_vectors();
        set_en(6'h3F);
        for (int i = 0; i < 5; i++) begin
            drive_src(i, 1'b1);
            expect_vec(16'(3 + 8 * i), "R3 vector table");
            accept();
            drive_src(i, 1'b0);
            do_ret();
        end
        quiesce();
    endtask

    task automatic t_poll_order();
        for (int i = 0; i < 5; i++) drive_src(i, 1'b1);
        repeat (3) tick();
        set_en(6'h3F);
        expect_vec(16'h0003, "R4 poll order first");
        repeat (3) tick();
        check(irq_valid && irq_vector == 16'h0003, "R12 offer held until ack",
              int'(irq_vector), 3);
        for (int i = 0; i < 5; i++) begin
            if (i > 0) expect_vec(16'(3 + 8 * i), "R4 poll order next");
            accept();
            if (i == 0) expect_none("R6 low blocks low");
            drive_src(i, 1'b0);
            do_ret();
        end
        quiesce();
    endtask

    task automatic t_hi_over_lo();
        set_pri(5'b10000);
        ext_req_n[0] = 1'b0; ser_evt = 1'b1;
        repeat (3) tick();
        set_en(6'h3F);
        expect_vec(16'h0023, "R5 high beats low");
        accept();
        check(in_svc_hi == 1'b1 && in_svc_lo == 1'b0, "R9 high entered",
              int'({in_svc_hi, in_svc_lo}), 2);
        ser_evt = 1'b0;
        do_ret();
        expect_vec(16'h0003, "R11 low taken after ret");
        accept();
        ext_req_n[0] = 1'b1;
        do_ret();
        quiesce();
    endtask

    task automatic t_nesting();
        set_pri(5'b11000);
        set_en(6'h3F);
        ext_req_n[1] = 1'b0;
        expect_vec(16'h0013, "R3 ext1 vector");
        accept();
        tmr_ovf[0] = 1'b1;
        expect_none("R6 low not preempted by low");
        tmr_ovf[1] = 1'b1;
        expect_vec(16'h001B, "R7 high preempts low");
        accept();
        check(in_svc_hi && in_svc_lo, "R7 both levels in service",
              int'({in_svc_hi, in_svc_lo}), 3);
        ser_evt = 1'b1;
        expect_none("R8 high not preempted");
        tmr_ovf[1] = 1'b0;
        do_ret();
        check(!in_svc_hi && in_svc_lo, "R9 ret clears high only",
              int'({in_svc_hi, in_svc_lo}), 1);
        expect_vec(16'h0023, "R11 held high after ret");
        accept();
        ser_evt = 1'b0;
        do_ret();
        check(!in_svc_hi && in_svc_lo, "R9 low kept", int'({in_svc_hi, in_svc_lo}), 1);
        ext_req_n[1] = 1'b1;
        do_ret();
        check(!in_svc_hi && !in_svc_lo, "R9 ret clears low",
              int'({in_svc_hi, in_svc_lo}), 0);
        expect_vec(16'h000B, "R11 held low after ret");
        accept();
        tmr_ovf[0] = 1'b0;
        do_ret();
        quiesce();
    endtask

    task automatic t_edge_level();
        ext_edge_mode = 2'b01;
        set_en(6'h3F);
        repeat (3) tick();
        ext_req_n[0] = 1'b0;
        expect_vec(16'h0003, "R10 falling edge requests");
        accept();
        do_ret();
        expect_none("R10 held low edge no repeat");
        ext_req_n[0] = 1'b1;
        repeat (3) tick();
        ext_req_n[0] = 1'b0;
        expect_vec(16'h0003, "R10 second edge");
        accept();
        ext_req_n[0] = 1'b1;
        do_ret();
        ext_req_n[1] = 1'b0;
        expect_vec(16'h0013, "R11 level first");
        accept();
        do_ret();
        expect_vec(16'h0013, "R11 level repeats while held");
        accept();
        ext_req_n[1] = 1'b1;
        do_ret();
        quiesce();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_global_mask();
        t_src_enable();
        t_vectors();
        t_poll_order();
        t_hi_over_lo();
        t_nesting();
        t_edge_level();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule